// File: doc/BRIEF.md
# Masked Processor Control Register Bank

This block holds the thirty-two 32-bit control registers of a small soft processor core. Each register has two masks that are fixed when the design is elaborated. One mask marks the bits that software may write. The other marks the bits that only hardware may change. A bit that is in neither mask is reserved and always reads as zero. A register with both masks empty is reserved as a whole: it has no storage and always reads zero. The masks depend on one parameter, `MMU_EN`, which adds the translation-unit registers and two extra status bits.

The core reaches the bank through four paths:
- A privileged read port and a privileged write port, each selected by a 5-bit register number.
- An exception-return port that reloads the status register.
- Hardware-update inputs that load the exception cause, the pending interrupt lines and the hardware-owned fields of the TLB control register.

A software write stores `(data AND writable) OR (old AND hardware-owned)`.

A small two-state machine drives the interrupt-state-changed strobe:
- `NTF_IDLE` is the rest state.
- The transition `idle_to_pulse` is taken on any software write to the status or interrupt-enable register. It enters `NTF_PULSE`, which drives the strobe for one cycle.
- The transition `pulse_to_idle` follows when no new write arrives. `pulse_to_pulse` is taken on back-to-back writes, so the strobe stays high.

Register map:

| Index | Register |
|---|---|
| 0 | status |
| 1 | exception-saved status |
| 2 | break-saved status |
| 3 | interrupt enable |
| 4 | interrupt pending |
| 5 | core identity |
| 6 | exception cause |
| 7 | faulting address |
| 8 | page-table address |
| 9 | TLB data |
| 10 | TLB control |
| 11 to 31 | reserved, including the configuration register (11) and the two protection-unit registers (12, 13) |

Top module: `crf_ctrl_bank`

## Requirements
- R1: After reset every register reads zero except the core-identity register (index 4'd5), which reads the `CORE_ID` parameter.
- R2: A register whose two masks are both zero (indices 11 to 31 always, and 8 to 10 when `MMU_EN`=0) reads zero, and software writes to it leave it at zero.
- R3: A software write stores `(wr_data & writable) | (current & hardware_owned)`. Hardware-owned bits keep their value, and reserved bits become zero.
- R4: A software write to a register with an empty writable mask has no effect. These registers are interrupt pending (4), core identity (5) and exception cause (6), which are wholly hardware-owned.
- R5: In status (0), bit 0 (previous interrupt enable) is writable. With `MMU_EN`=1, bit 1 (user mode) and bit 2 (exception handling) are also writable. All other status bits read zero.
- R6: Registers 1, 2, 3 and 7 are fully writable. Register 9 (TLB data) is fully writable when `MMU_EN`=1.
- R7: With `MMU_EN`=1, page-table address (8) has writable mask 32'hFFFF_FFFC: a table-entry field in bits [21:2] and a table-base field in bits [31:22]. Bits [1:0] read zero.
- R8: With `MMU_EN`=1, TLB control (10) has these hardware-owned fields:
  - dirty, bit 0
  - permission, bits [3:1]
  - bad-entry, bit 24
  - double-miss, bit 25

  It has these writable fields:
  - process id, bits [17:4]
  - write-enable, bit 18
  - read-enable, bit 19
  - way, bits [23:20]

  Bits [31:26] read zero.
- R9: When `eret_en` is high, status is loaded with `eret_status` ANDed with the status writable mask, with no hardware-owned merge. This path wins over a software write to status in the same cycle.
- R10: `hw_cause_en` loads all of register 6 and `hw_pend_en` loads all of register 4. `hw_tlbm_en` loads only the hardware-owned bits of register 10 and keeps its writable bits. A hardware update wins over a software write to the same register in the same cycle.
- R11: A software write to status (0) or interrupt enable (3) raises `irq_state_chg` for exactly the next cycle. Writes to other registers do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 5 | Read register number |
| rd_data | output | 32 | Read data, combinational from rd_idx |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 5 | Write register number |
| wr_data | input | 32 | Software write data |
| eret_en | input | 1 | Exception-return reload of status |
| eret_status | input | 32 | Status value restored on exception return |
| hw_cause_en | input | 1 | Hardware load of exception cause |
| hw_cause | input | 32 | Exception cause value |
| hw_pend_en | input | 1 | Hardware load of interrupt pending |
| hw_pend | input | 32 | Pending interrupt lines |
| hw_tlbm_en | input | 1 | Hardware load of TLB control owned fields |
| hw_tlbm | input | 32 | TLB control hardware field values |
| irq_state_chg | output | 1 | One-cycle strobe after status or interrupt-enable write |

## Verification
The read port is combinational, so a software write, an exception return or a hardware update that is captured at one rising edge shows on `rd_data` within that same cycle. The strobe rises one register stage after the edge that takes the write and falls at the following edge. The bench drives every input at a falling edge and lets one rising edge pass. It then samples at the next falling edge, where both the new register value and the strobe are due. The bench sweeps every register number with several data patterns on two instances, one with the translation option and one without. Each expected value comes from a mask model kept in the bench.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int IX_STAT       = 0;
    localparam int IX_ESTAT      = 1;
    localparam int IX_BSTAT      = 2;
    localparam int IX_IRQ_EN     = 3;
    localparam int IX_IRQ_PEND   = 4;
    localparam int IX_CORE_ID    = 5;
    localparam int IX_CAUSE      = 6;
    localparam int IX_FAULT_ADDR = 7;
    localparam int IX_PT_ADDR    = 8;
    localparam int IX_TLB_DATA   = 9;
    localparam int IX_TLB_CTRL   = 10;

    localparam logic [31:0] STAT_WR_BASE = 32'h0000_0001;
    localparam logic [31:0] STAT_WR_MMU  = 32'h0000_0007;
    localparam logic [31:0] PT_ADDR_WR   = 32'hFFFF_FFFC;
    localparam logic [31:0] TLBC_WR      = 32'h00FF_FFF0;
    localparam logic [31:0] TLBC_RO      = 32'h0300_000F;

    typedef enum logic [0:0] {
        NTF_IDLE  = 1'b0,
        NTF_PULSE = 1'b1
    } ntf_state_t;

    function automatic logic [31:0] wr_mask_of(input int idx, input bit mmu);
        logic [31:0] m;
        m = '0;
        case (idx)
            IX_STAT:                                         m = mmu ? STAT_WR_MMU : STAT_WR_BASE;
            IX_ESTAT, IX_BSTAT, IX_IRQ_EN, IX_FAULT_ADDR:    m = '1;
            IX_PT_ADDR:                                      m = mmu ? PT_ADDR_WR : '0;
            IX_TLB_DATA:                                     m = mmu ? '1 : '0;
            IX_TLB_CTRL:                                     m = mmu ? TLBC_WR : '0;
            default:                                         m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] ro_mask_of(input int idx, input bit mmu);
        logic [31:0] m;
        m = '0;
        case (idx)
            IX_IRQ_PEND, IX_CORE_ID, IX_CAUSE: m = '1;
            IX_TLB_CTRL:                       m = mmu ? TLBC_RO : '0;
            default:                           m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/crf_reg_slot.sv
module crf_reg_slot #(
    parameter int          DW    = 32,
    parameter logic [31:0] WR    = '0,
    parameter logic [31:0] RO    = '0,
    parameter logic [31:0] RST   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_hit,
    input  logic [DW-1:0] sw_data,
    input  logic          hw_hit,
    input  logic [DW-1:0] hw_data,
    input  logic          eret_hit,
    input  logic [DW-1:0] eret_data,
    output logic [DW-1:0] q
);

    localparam logic [DW-1:0] WRM = WR[DW-1:0];
    localparam logic [DW-1:0] ROM = RO[DW-1:0];
    localparam bit            SW_OPEN = (WR != '0);

    logic [DW-1:0] q_nx;

    always_comb begin
        q_nx = q;
        if (hw_hit) begin
            q_nx = (q & ~ROM) | (hw_data & ROM);
        end else if (eret_hit) begin
            q_nx = eret_data & WRM;
        end else if (sw_hit && SW_OPEN) begin
            q_nx = (sw_data & WRM) | (q & ROM);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST[DW-1:0];
        else        q <= q_nx;
    end

    // R3: merge of software data with kept hardware-owned bits
    a_r3_sw_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_hit && !hw_hit && !eret_hit) |=>
            (q == (($past(sw_data) & WRM) | ($past(q) & ROM)) || !SW_OPEN));

    // R4: closed register ignores software writes
    a_r4_closed_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_hit && !hw_hit && !eret_hit && !SW_OPEN) |=> $stable(q));

    // R9: exception return passes through writable mask only
    a_r9_eret_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_hit && !hw_hit) |=> (q == ($past(eret_data) & WRM)));

    // R10: hardware update lands in owned bits
    a_r10_hw_load: assert property (@(posedge clk) disable iff (!rst_n)
        hw_hit |=> ((q & ROM) == ($past(hw_data) & ROM)));

endmodule

// File: rtl/crf_notify_fsm.sv
module crf_notify_fsm
    import crf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic strobe
);

    ntf_state_t state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NTF_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            NTF_IDLE:  state_nx = trig ? NTF_PULSE : NTF_IDLE;
            NTF_PULSE: state_nx = trig ? NTF_PULSE : NTF_IDLE;
            default:   state_nx = NTF_IDLE;
        endcase
    end

    always_comb begin
        strobe = 1'b0;
        unique case (state_q)
            NTF_IDLE:  strobe = 1'b0;
            NTF_PULSE: strobe = 1'b1;
            default:   strobe = 1'b0;
        endcase
    end

    // R11: strobe only follows a trigger
    a_r11_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> strobe);
    a_r11_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> !strobe);

endmodule

// File: rtl/crf_ctrl_bank.sv
module crf_ctrl_bank
    import crf_pkg::*;
#(
    parameter int          AW      = 5,
    parameter int          DW      = 32,
    parameter bit          MMU_EN  = 1'b1,
    parameter logic [31:0] CORE_ID = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          eret_en,
    input  logic [DW-1:0] eret_status,
    input  logic          hw_cause_en,
    input  logic [DW-1:0] hw_cause,
    input  logic          hw_pend_en,
    input  logic [DW-1:0] hw_pend,
    input  logic          hw_tlbm_en,
    input  logic [DW-1:0] hw_tlbm,
    output logic          irq_state_chg
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0]   cr_q [NREG];
    logic [NREG-1:0] live;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [31:0] WRM = wr_mask_of(i, MMU_EN);
        localparam logic [31:0] ROM = ro_mask_of(i, MMU_EN);
        localparam logic [31:0] RSV = (i == IX_CORE_ID) ? CORE_ID : 32'h0;

        if ((WRM | ROM) == 32'h0) begin : g_rsvd
            assign live[i] = 1'b0;
            assign cr_q[i] = '0;
        end else begin : g_live
            logic          hw_hit;
            logic [DW-1:0] hw_val;

            assign live[i] = 1'b1;
            assign hw_hit = (i == IX_CAUSE)    ? hw_cause_en :
                            (i == IX_IRQ_PEND) ? hw_pend_en  :
                            (i == IX_TLB_CTRL) ? hw_tlbm_en  : 1'b0;
            assign hw_val = (i == IX_CAUSE)    ? hw_cause :
                            (i == IX_IRQ_PEND) ? hw_pend  : hw_tlbm;

            crf_reg_slot #(
                .DW (DW),
                .WR (WRM),
                .RO (ROM),
                .RST(RSV)
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .sw_hit   (wr_en && (wr_idx == AW'(i))),
                .sw_data  (wr_data),
                .hw_hit   (hw_hit),
                .hw_data  (hw_val),
                .eret_hit (eret_en && (i == IX_STAT)),
                .eret_data(eret_status),
                .q        (cr_q[i])
            );
        end
    end

    always_comb begin
        rd_data = live[rd_idx] ? cr_q[rd_idx] : '0;
    end

    crf_notify_fsm u_notify (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (wr_en && (wr_idx == AW'(IX_STAT) || wr_idx == AW'(IX_IRQ_EN))),
        .strobe(irq_state_chg)
    );

    // R2: reserved registers never expose data
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !live[rd_idx] |-> (rd_data == '0));

endmodule

// File: tb/crf_ctrl_bank_bench.sv
`timescale 1ns/1ps
module crf_ctrl_bank_bench;

    localparam logic [31:0] CID = 32'h5A17_0C0D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_idx = '0, wr_idx = '0;
    logic [31:0] wr_data = '0, eret_status = '0, hw_cause = '0, hw_pend = '0, hw_tlbm = '0;
    logic        wr_en = 0, eret_en = 0, hw_cause_en = 0, hw_pend_en = 0, hw_tlbm_en = 0;
    logic [31:0] rd_a, rd_b;
    logic        chg_a, chg_b;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] ma [32];
    logic [31:0] mb [32];

    always #2.5 clk = ~clk;

    crf_ctrl_bank #(.MMU_EN(1'b1), .CORE_ID(CID)) u_crf_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_a),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .eret_en(eret_en), .eret_status(eret_status),
        .hw_cause_en(hw_cause_en), .hw_cause(hw_cause),
        .hw_pend_en(hw_pend_en), .hw_pend(hw_pend),
        .hw_tlbm_en(hw_tlbm_en), .hw_tlbm(hw_tlbm), .irq_state_chg(chg_a));

    crf_ctrl_bank #(.MMU_EN(1'b0), .CORE_ID(CID)) u_nommu (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .eret_en(eret_en), .eret_status(eret_status),
        .hw_cause_en(hw_cause_en), .hw_cause(hw_cause),
        .hw_pend_en(hw_pend_en), .hw_pend(hw_pend),
        .hw_tlbm_en(hw_tlbm_en), .hw_tlbm(hw_tlbm), .irq_state_chg(chg_b));

    function automatic logic [31:0] wm(input int i, input bit mmu);
        if (i == 0) return mmu ? 32'h7 : 32'h1;
        if (i == 1 || i == 2 || i == 3 || i == 7) return 32'hFFFF_FFFF;
        if (i == 8) return mmu ? 32'hFFFF_FFFC : 32'h0;
        if (i == 9) return mmu ? 32'hFFFF_FFFF : 32'h0;
        if (i == 10) return mmu ? 32'h00FF_FFF0 : 32'h0;
        return 32'h0;
    endfunction

    function automatic logic [31:0] om(input int i, input bit mmu);
        if (i == 4 || i == 5 || i == 6) return 32'hFFFF_FFFF;
        if (i == 10) return mmu ? 32'h0300_000F : 32'h0;
        return 32'h0;
    endfunction

    function automatic string tag_of(input int i);
        if (i == 0) return "R5";
        if (i == 4 || i == 5 || i == 6) return "R4";
        if (i == 8) return "R7";
        if (i == 10) return "R8";
        if (i == 1 || i == 2 || i == 3 || i == 7 || i == 9) return "R6";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input int i, input string tag);
        rd_idx = 5'(i);
        #0.5;
        chk({tag, " mmu"}, rd_a, ma[i]);
        chk({tag, " nommu"}, rd_b, mb[i]);
    endtask

    task automatic sw_upd(input int i, input logic [31:0] d);
        if (wm(i, 1) != 0) ma[i] = (d & wm(i, 1)) | (ma[i] & om(i, 1));
        if (wm(i, 0) != 0) mb[i] = (d & wm(i, 0)) | (mb[i] & om(i, 0));
    endtask

    task automatic sw_wr(input int i, input logic [31:0] d);
        wr_en = 1; wr_idx = 5'(i); wr_data = d;
        step();
        wr_en = 0;
        sw_upd(i, d);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            ma[i] = (i == 5) ? CID : 32'h0;
            mb[i] = (i == 5) ? CID : 32'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset values
        for (int i = 0; i < 32; i++) rd_chk(i, "R1");
        chk("R1 strobe idle", {31'b0, chg_a}, 32'h0);

        // R2 R3 R4 R5 R6 R7 R8: sweep every register with patterns
        for (int i = 0; i < 32; i++) begin
            for (int p = 0; p < 4; p++) begin
                logic [31:0] d;
                d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
                    (p == 2) ? 32'hA5C3_5A3C : (32'h0101_0101 * (i + 1));
                sw_wr(i, d);
                rd_chk(i, tag_of(i));
            end
        end

        // R11 strobe after status and interrupt-enable writes
        sw_wr(0, 32'h1);
        chk("R11 status write strobe", {30'b0, chg_b, chg_a}, 32'h3);
        step();
        chk("R11 strobe one cycle", {30'b0, chg_b, chg_a}, 32'h0);
        sw_wr(3, 32'h5);
        chk("R11 ienable write strobe", {31'b0, chg_a}, 32'h1);
        sw_wr(1, 32'h5);
        chk("R11 other write no strobe", {31'b0, chg_a}, 32'h0);

        // R10 hardware loads
        hw_cause_en = 1; hw_cause = 32'h0000_001C;
        hw_pend_en = 1;  hw_pend = 32'h8000_0011;
        step();
        hw_cause_en = 0; hw_pend_en = 0;
        ma[6] = 32'h1C; mb[6] = 32'h1C; ma[4] = 32'h8000_0011; mb[4] = 32'h8000_0011;
        rd_chk(6, "R10 cause load");
        rd_chk(4, "R10 pend load");
        sw_wr(6, 32'hFFFF_FFFF);
        rd_chk(6, "R4 cause sw ignored");

        // R10 hw wins over sw on same register
        hw_cause_en = 1; hw_cause = 32'h0000_0002;
        wr_en = 1; wr_idx = 5'd6; wr_data = 32'h1234_5678;
        step();
        hw_cause_en = 0; wr_en = 0;
        ma[6] = 32'h2; mb[6] = 32'h2;
        rd_chk(6, "R10 hw beats sw");

        // R8 R10 tlb control hw fields, R3 kept across sw write
        sw_wr(10, 32'h0012_3450);
        hw_tlbm_en = 1; hw_tlbm = 32'hFFFF_FFFF;
        step();
        hw_tlbm_en = 0;
        ma[10] = (ma[10] & ~32'h0300_000F) | 32'h0300_000F;
        rd_chk(10, "R10 tlbctrl hw owned only");
        sw_wr(10, 32'h0);
        rd_chk(10, "R3 owned bits kept");
        hw_tlbm_en = 1; hw_tlbm = 32'h0200_0005;
        wr_en = 1; wr_idx = 5'd10; wr_data = 32'h00AB_CDE0;
        step();
        hw_tlbm_en = 0; wr_en = 0;
        ma[10] = (ma[10] & ~32'h0300_000F) | 32'h0200_0005;
        rd_chk(10, "R10 tlbctrl hw beats sw");

        // R9 exception return
        eret_en = 1; eret_status = 32'hFFFF_FFFF;
        step();
        eret_en = 0;
        ma[0] = 32'h7; mb[0] = 32'h1;
        rd_chk(0, "R9 eret mask");
        eret_en = 1; eret_status = 32'h0000_0002;
        wr_en = 1; wr_idx = 5'd0; wr_data = 32'h1;
        step();
        eret_en = 0; wr_en = 0;
        ma[0] = 32'h2; mb[0] = 32'h0;
        rd_chk(0, "R9 eret beats sw");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule